// File: doc/BRIEF.md
# Line Prefetch Issue Unit

This unit turns one decoded cache-line prefetch operation into requests for the memory side. It can accept one operation per cycle. Each operation carries:

- a base register value and its NaT bit;
- either an index register value with its own NaT bit, or a 9-bit immediate;
- a 2-bit addressing form;
- an exclusive qualifier;
- a fault-type completer;
- a locality hint;
- the cacheability attribute of the page.

One cycle after it accepts an operation, the unit can present two line-aligned requests. The first is an explicit prefetch on a valid/ready channel. The second is an implicit prefetch hint on its own channel, aimed at the line of the post-incremented base. In the update forms the unit also produces a write-back of the new base register value and its NaT bit.

The unit is placed after decode and before the memory request queue. The explicit channel applies back-pressure through `in_ready`. The hint channel never stalls the unit. A hint that is still waiting is thrown away as soon as the next operation is accepted. Fault delivery, translation and the cache arrays sit outside the unit. The fault-eligible output is a flag only.

Top module: `pfx_line_issue`

## Requirements
- R1: With form code 0 (no update), the unit asserts no base write-back and no implicit hint. The explicit request address is the base value with its low line bits cleared.
- R2: With form code 1 (register update), the write-back value is base + index, and `wb_valid` is high for exactly the cycle after acceptance.
- R3: With form code 2 (immediate update), the 9-bit immediate (bit 8 is the sign) is sign-extended to the register width before it is added to the base.
- R4: In register-update form, a set index NaT bit sets `wb_nat`. No error flag is raised. The explicit request and the hint are not affected.
- R5: A set base NaT bit suppresses the explicit request and the hint. In the update forms the post-increment is still written back, with `wb_nat` set.
- R6: In the update forms with the base NaT bit clear, an implicit hint is issued. Its address is the line of the post-incremented base, and it carries the operation's locality hint.
- R7: When `in_cacheable` is 0, no explicit request is issued. The write-back and the hint are still produced.
- R8: The explicit request forwards the exclusive qualifier and the locality hint. `ex_fault_ok` is 1 only when `in_fault_kind` is 1 (faulting). A value of 0 means no faults.
- R9: Every request address has its low log2(LINE_BYTES) bits cleared. LINE_BYTES is a power of two and at least 32.
- R10: Form code 3 is illegal. It raises `err_form` for one cycle and produces no request and no write-back.
- R11: All results appear one cycle after acceptance. While `ex_valid` is high and `ex_ready` is low, the explicit request is held unchanged and `in_ready` is low.
- R12: A hint that is not taken is held until the next operation is accepted. That operation replaces the hint or discards it. `hint_ready` never lowers `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can accept an operation |
| in_form | input | 2 | Addressing form: 0 none, 1 register, 2 immediate, 3 illegal |
| in_base | input | XLEN | Base register value |
| in_base_nat | input | 1 | Base register NaT bit |
| in_idx | input | XLEN | Index register value |
| in_idx_nat | input | 1 | Index register NaT bit |
| in_imm | input | 9 | Signed immediate increment |
| in_excl | input | 1 | Exclusive qualifier |
| in_fault_kind | input | 1 | 1 = faulting completer, 0 = non-faulting |
| in_hint | input | HINT_W | Locality hint |
| in_cacheable | input | 1 | Page is cacheable |
| ex_valid | output | 1 | Explicit request valid |
| ex_ready | input | 1 | Memory side takes the explicit request |
| ex_addr | output | XLEN | Explicit request line address |
| ex_excl | output | 1 | Exclusive install allowed |
| ex_fault_ok | output | 1 | Request may raise load-style faults |
| ex_loc | output | HINT_W | Explicit request locality hint |
| hint_valid | output | 1 | Implicit hint valid |
| hint_ready | input | 1 | Memory side takes the hint |
| hint_addr | output | XLEN | Hint line address |
| hint_loc | output | HINT_W | Hint locality hint |
| wb_valid | output | 1 | Base write-back valid |
| wb_base | output | XLEN | New base value |
| wb_nat | output | 1 | New base NaT bit |
| err_form | output | 1 | Illegal form seen |

## Verification
The bench drives negative and positive immediates. A design that zero-extends the immediate, or adds it with the wrong width, writes back the wrong base and hints the wrong line. It checks an index NaT bit together with a clear base NaT bit: a design that mixes up the two either drops the explicit request or fails to poison the write-back. It checks a non-cacheable page in an update form, where a design that gates too much loses the hint or the write-back. It stalls the explicit channel while a second operation waits, and holds a hint across an idle cycle before the next operation drops it. A design that lets the hint stall the unit, accepts input during back-pressure, or lets a held hint survive a new operation fails these checks.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_REG  = 2'd1,
        FORM_IMM  = 2'd2,
        FORM_BAD  = 2'd3
    } pfx_form_e;

endpackage

// File: rtl/pfx_addr_calc.sv
module pfx_addr_calc #(
    parameter int XLEN       = 64,
    parameter int IMM_W      = 9,
    parameter int LINE_BYTES = 64
) (
    input  logic [XLEN-1:0]       base_i,
    input  logic [XLEN-1:0]       idx_i,
    input  logic [IMM_W-1:0]      imm_i,
    input  pfx_pkg::pfx_form_e    form_i,
    output logic [XLEN-1:0]       next_base_o,
    output logic [XLEN-1:0]       base_line_o,
    output logic [XLEN-1:0]       next_line_o
);
    localparam logic [XLEN-1:0] LINE_MASK = ~(XLEN'(LINE_BYTES - 1));

    if (LINE_BYTES < 32 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
        $error("LINE_BYTES must be a power of two of at least 32");
    end

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] incr;

    always_comb begin
        imm_ext = {{(XLEN - IMM_W){imm_i[IMM_W-1]}}, imm_i};
        case (form_i)
            pfx_pkg::FORM_REG: incr = idx_i;
            pfx_pkg::FORM_IMM: incr = imm_ext;
            default:           incr = '0;
        endcase
        next_base_o = base_i + incr;
        base_line_o = base_i & LINE_MASK;
        next_line_o = next_base_o & LINE_MASK;
    end
endmodule

// File: rtl/pfx_issue_gate.sv
module pfx_issue_gate (
    input  pfx_pkg::pfx_form_e form_i,
    input  logic               base_nat_i,
    input  logic               idx_nat_i,
    input  logic               cacheable_i,
    output logic               legal_o,
    output logic               update_o,
    output logic               do_ex_o,
    output logic               do_hint_o,
    output logic               wb_nat_o
);
    always_comb begin
        legal_o   = (form_i != pfx_pkg::FORM_BAD);
        update_o  = (form_i == pfx_pkg::FORM_REG) || (form_i == pfx_pkg::FORM_IMM);
        do_ex_o   = legal_o && !base_nat_i && cacheable_i;
        do_hint_o = update_o && !base_nat_i;
        wb_nat_o  = base_nat_i || ((form_i == pfx_pkg::FORM_REG) && idx_nat_i);
    end
endmodule

// File: rtl/pfx_line_issue.sv
module pfx_line_issue #(
    parameter int XLEN       = 64,
    parameter int LINE_BYTES = 64,
    parameter int HINT_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_form,
    input  logic [XLEN-1:0]   in_base,
    input  logic              in_base_nat,
    input  logic [XLEN-1:0]   in_idx,
    input  logic              in_idx_nat,
    input  logic [8:0]        in_imm,
    input  logic              in_excl,
    input  logic              in_fault_kind,
    input  logic [HINT_W-1:0] in_hint,
    input  logic              in_cacheable,
    output logic              ex_valid,
    input  logic              ex_ready,
    output logic [XLEN-1:0]   ex_addr,
    output logic              ex_excl,
    output logic              ex_fault_ok,
    output logic [HINT_W-1:0] ex_loc,
    output logic              hint_valid,
    input  logic              hint_ready,
    output logic [XLEN-1:0]   hint_addr,
    output logic [HINT_W-1:0] hint_loc,
    output logic              wb_valid,
    output logic [XLEN-1:0]   wb_base,
    output logic              wb_nat,
    output logic              err_form
);
    localparam int IMM_W = 9;

    typedef struct packed {
        logic              ex_v;
        logic [XLEN-1:0]   ex_addr;
        logic              ex_excl;
        logic              ex_fault_ok;
        logic [HINT_W-1:0] ex_loc;
        logic              hn_v;
        logic [XLEN-1:0]   hn_addr;
        logic [HINT_W-1:0] hn_loc;
        logic              wb_v;
        logic [XLEN-1:0]   wb_val;
        logic              wb_nat;
        logic              err;
    } pfx_state_t;

    pfx_state_t st_d, st_q;

    pfx_pkg::pfx_form_e form;
    logic [XLEN-1:0] next_base, base_line, next_line;
    logic legal, update, do_ex, do_hint, nat_out;
    logic accept;

    assign form = pfx_pkg::pfx_form_e'(in_form);

    pfx_addr_calc #(
        .XLEN       (XLEN),
        .IMM_W      (IMM_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_addr (
        .base_i      (in_base),
        .idx_i       (in_idx),
        .imm_i       (in_imm),
        .form_i      (form),
        .next_base_o (next_base),
        .base_line_o (base_line),
        .next_line_o (next_line)
    );

    pfx_issue_gate u_gate (
        .form_i      (form),
        .base_nat_i  (in_base_nat),
        .idx_nat_i   (in_idx_nat),
        .cacheable_i (in_cacheable),
        .legal_o     (legal),
        .update_o    (update),
        .do_ex_o     (do_ex),
        .do_hint_o   (do_hint),
        .wb_nat_o    (nat_out)
    );

    assign in_ready = !(st_q.ex_v && !ex_ready);
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;

        // explicit channel: load on a new request, clear once taken, else hold
        if (accept && do_ex) begin
            st_d.ex_v        = 1'b1;
            st_d.ex_addr     = base_line;
            st_d.ex_excl     = in_excl;
            st_d.ex_fault_ok = in_fault_kind;
            st_d.ex_loc      = in_hint;
        end else if (accept || ex_ready) begin
            st_d.ex_v = 1'b0;
        end

        // hint channel: each accepted operation replaces or drops a waiting hint
        if (accept) begin
            st_d.hn_v = do_hint;
            if (do_hint) begin
                st_d.hn_addr = next_line;
                st_d.hn_loc  = in_hint;
            end
        end else if (hint_ready) begin
            st_d.hn_v = 1'b0;
        end

        // write-back and error are single-cycle pulses
        st_d.wb_v = accept && update;
        if (accept && update) begin
            st_d.wb_val = next_base;
            st_d.wb_nat = nat_out;
        end
        st_d.err = accept && !legal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ex_valid    = st_q.ex_v;
    assign ex_addr     = st_q.ex_addr;
    assign ex_excl     = st_q.ex_excl;
    assign ex_fault_ok = st_q.ex_fault_ok;
    assign ex_loc      = st_q.ex_loc;
    assign hint_valid  = st_q.hn_v;
    assign hint_addr   = st_q.hn_addr;
    assign hint_loc    = st_q.hn_loc;
    assign wb_valid    = st_q.wb_v;
    assign wb_base     = st_q.wb_val;
    assign wb_nat      = st_q.wb_nat;
    assign err_form    = st_q.err;
endmodule

// File: rtl/pfx_line_issue_chk.sv
module pfx_line_issue_chk #(
    parameter int XLEN     = 64,
    parameter int LINE_LSB = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            ex_valid,
    input logic            ex_ready,
    input logic [XLEN-1:0] ex_addr,
    input logic            hint_valid,
    input logic            hint_ready,
    input logic [XLEN-1:0] hint_addr,
    input logic            wb_valid,
    input logic            err_form
);
    a_r9_ex_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |-> (ex_addr[LINE_LSB-1:0] == '0));

    a_r9_hint_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        hint_valid |-> (hint_addr[LINE_LSB-1:0] == '0));

    a_r10_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        err_form |-> !wb_valid);

    a_r11_ex_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_ready) |=> (ex_valid && $stable(ex_addr)));

    a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_ready) |-> !in_ready);

    a_r12_hint_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> in_ready);

    a_r12_hint_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_valid && !hint_ready && !(in_valid && in_ready))
            |=> (hint_valid && $stable(hint_addr)));
endmodule

bind pfx_line_issue pfx_line_issue_chk #(
    .XLEN     (XLEN),
    .LINE_LSB ($clog2(LINE_BYTES))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .ex_valid   (ex_valid),
    .ex_ready   (ex_ready),
    .ex_addr    (ex_addr),
    .hint_valid (hint_valid),
    .hint_ready (hint_ready),
    .hint_addr  (hint_addr),
    .wb_valid   (wb_valid),
    .err_form   (err_form)
);

// File: tb/tb_pfx_line_issue.sv
module tb_pfx_line_issue;
    localparam int XLEN = 64;
    localparam int HW   = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready;
    logic [1:0] in_form;
    logic [XLEN-1:0] in_base, in_idx;
    logic in_base_nat, in_idx_nat;
    logic [8:0] in_imm;
    logic in_excl, in_fault_kind, in_cacheable;
    logic [HW-1:0] in_hint;
    logic ex_valid, ex_ready, ex_excl, ex_fault_ok;
    logic [XLEN-1:0] ex_addr, hint_addr, wb_base;
    logic [HW-1:0] ex_loc, hint_loc;
    logic hint_valid, hint_ready, wb_valid, wb_nat, err_form;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pfx_line_issue #(.XLEN(XLEN), .LINE_BYTES(64), .HINT_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_form(in_form), .in_base(in_base), .in_base_nat(in_base_nat),
        .in_idx(in_idx), .in_idx_nat(in_idx_nat), .in_imm(in_imm),
        .in_excl(in_excl), .in_fault_kind(in_fault_kind), .in_hint(in_hint),
        .in_cacheable(in_cacheable), .ex_valid(ex_valid), .ex_ready(ex_ready),
        .ex_addr(ex_addr), .ex_excl(ex_excl), .ex_fault_ok(ex_fault_ok),
        .ex_loc(ex_loc), .hint_valid(hint_valid), .hint_ready(hint_ready),
        .hint_addr(hint_addr), .hint_loc(hint_loc), .wb_valid(wb_valid),
        .wb_base(wb_base), .wb_nat(wb_nat), .err_form(err_form)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one operation for one cycle, then sample half a cycle after the capturing edge
    task automatic issue(input logic [1:0] form, input logic [63:0] base, input logic bnat,
                         input logic [63:0] idx, input logic inat, input logic [8:0] imm,
                         input logic excl, input logic fk, input logic [1:0] hint,
                         input logic cach);
        @(negedge clk);
        in_valid = 1'b1; in_form = form; in_base = base; in_base_nat = bnat;
        in_idx = idx; in_idx_nat = inat; in_imm = imm; in_excl = excl;
        in_fault_kind = fk; in_hint = hint; in_cacheable = cach;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11", "ex_valid after reset", 64'(ex_valid), 64'd0);
        chk("R11", "hint_valid after reset", 64'(hint_valid), 64'd0);
        chk("R11", "wb_valid after reset", 64'(wb_valid), 64'd0);
        chk("R11", "in_ready after reset", 64'(in_ready), 64'd1);
    endtask

    task automatic t_no_update;
        issue(2'd0, 64'h1000_0047, 1'b0, 64'h55, 1'b0, 9'h0, 1'b1, 1'b1, 2'd2, 1'b1);
        chk("R1", "ex_valid", 64'(ex_valid), 64'd1);
        chk("R9", "ex_addr aligned", ex_addr, 64'h1000_0040);
        chk("R1", "no wb", 64'(wb_valid), 64'd0);
        chk("R1", "no hint", 64'(hint_valid), 64'd0);
        chk("R8", "excl fwd", 64'(ex_excl), 64'd1);
        chk("R8", "fault ok", 64'(ex_fault_ok), 64'd1);
        chk("R8", "locality", 64'(ex_loc), 64'd2);
    endtask

    task automatic t_reg_update;
        issue(2'd1, 64'h2000, 1'b0, 64'h1C5, 1'b0, 9'h0, 1'b0, 1'b0, 2'd3, 1'b1);
        chk("R2", "wb_valid", 64'(wb_valid), 64'd1);
        chk("R2", "wb_base", wb_base, 64'h21C5);
        chk("R2", "wb_nat", 64'(wb_nat), 64'd0);
        chk("R6", "hint_valid", 64'(hint_valid), 64'd1);
        chk("R6", "hint_addr", hint_addr, 64'h21C0);
        chk("R6", "hint_loc", 64'(hint_loc), 64'd3);
        chk("R8", "non-faulting", 64'(ex_fault_ok), 64'd0);
        chk("R1", "ex_addr is pre-increment", ex_addr, 64'h2000);
        @(negedge clk);
        chk("R2", "wb pulse ends", 64'(wb_valid), 64'd0);
    endtask

    task automatic t_imm_update;
        issue(2'd2, 64'h3000, 1'b0, 64'h999, 1'b0, 9'h1F0, 1'b0, 1'b0, 2'd1, 1'b1);
        chk("R3", "negative imm wb", wb_base, 64'h2FF0);
        chk("R6", "negative imm hint", hint_addr, 64'h2FC0);
        issue(2'd2, 64'h100, 1'b0, 64'h999, 1'b0, 9'h0FF, 1'b0, 1'b0, 2'd1, 1'b1);
        chk("R3", "positive imm wb", wb_base, 64'h1FF);
        chk("R6", "positive imm hint", hint_addr, 64'h1C0);
    endtask

    task automatic t_idx_nat;
        issue(2'd1, 64'h5000, 1'b0, 64'h40, 1'b1, 9'h0, 1'b0, 1'b1, 2'd0, 1'b1);
        chk("R4", "wb_nat", 64'(wb_nat), 64'd1);
        chk("R4", "wb_base", wb_base, 64'h5040);
        chk("R4", "no err", 64'(err_form), 64'd0);
        chk("R4", "ex still issued", 64'(ex_valid), 64'd1);
        chk("R4", "hint still issued", 64'(hint_valid), 64'd1);
    endtask

    task automatic t_base_nat;
        issue(2'd2, 64'h6000, 1'b1, 64'h0, 1'b0, 9'h020, 1'b0, 1'b1, 2'd0, 1'b1);
        chk("R5", "no ex", 64'(ex_valid), 64'd0);
        chk("R5", "no hint", 64'(hint_valid), 64'd0);
        chk("R5", "wb_valid", 64'(wb_valid), 64'd1);
        chk("R5", "wb_base", wb_base, 64'h6020);
        chk("R5", "wb_nat", 64'(wb_nat), 64'd1);
        issue(2'd0, 64'h6000, 1'b1, 64'h0, 1'b0, 9'h0, 1'b0, 1'b1, 2'd0, 1'b1);
        chk("R5", "no-update nat: no ex", 64'(ex_valid), 64'd0);
        chk("R5", "no-update nat: no wb", 64'(wb_valid), 64'd0);
    endtask

    task automatic t_noncache;
        issue(2'd1, 64'h7000, 1'b0, 64'h100, 1'b0, 9'h0, 1'b1, 1'b1, 2'd1, 1'b0);
        chk("R7", "no ex", 64'(ex_valid), 64'd0);
        chk("R7", "hint kept", 64'(hint_valid), 64'd1);
        chk("R7", "hint addr", hint_addr, 64'h7100);
        chk("R7", "wb kept", wb_base, 64'h7100);
    endtask

    task automatic t_bad_form;
        issue(2'd3, 64'h8000, 1'b0, 64'h40, 1'b0, 9'h10, 1'b0, 1'b1, 2'd0, 1'b1);
        chk("R10", "err_form", 64'(err_form), 64'd1);
        chk("R10", "no ex", 64'(ex_valid), 64'd0);
        chk("R10", "no hint", 64'(hint_valid), 64'd0);
        chk("R10", "no wb", 64'(wb_valid), 64'd0);
        @(negedge clk);
        chk("R10", "err one cycle", 64'(err_form), 64'd0);
    endtask

    task automatic t_stall;
        ex_ready = 1'b0; hint_ready = 1'b0;
        issue(2'd1, 64'h9000, 1'b0, 64'h80, 1'b0, 9'h0, 1'b0, 1'b0, 2'd2, 1'b1);
        chk("R11", "ex held valid", 64'(ex_valid), 64'd1);
        chk("R11", "in_ready low", 64'(in_ready), 64'd0);
        // offer a second operation while stalled: it must not be taken
        in_valid = 1'b1; in_form = 2'd1; in_base = 64'hA000; in_idx = 64'h40;
        in_base_nat = 1'b0; in_idx_nat = 1'b0; in_cacheable = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11", "ex addr stable", ex_addr, 64'h9000);
        chk("R11", "blocked op no wb", 64'(wb_valid), 64'd0);
        chk("R12", "hint still held", hint_addr, 64'h9080);
        ex_ready = 1'b1;
        @(negedge clk);
        chk("R11", "ex cleared when taken", 64'(ex_valid), 64'd0);
        chk("R12", "hint held while not ready", 64'(hint_valid), 64'd1);
        chk("R12", "no stall from hint", 64'(in_ready), 64'd1);
        issue(2'd0, 64'hB000, 1'b0, 64'h0, 1'b0, 9'h0, 1'b0, 1'b0, 2'd0, 1'b1);
        chk("R12", "hint dropped by next op", 64'(hint_valid), 64'd0);
        issue(2'd1, 64'hC000, 1'b0, 64'h40, 1'b0, 9'h0, 1'b0, 1'b0, 2'd0, 1'b1);
        issue(2'd1, 64'hD000, 1'b0, 64'h80, 1'b0, 9'h0, 1'b0, 1'b0, 2'd0, 1'b1);
        chk("R12", "hint replaced", hint_addr, 64'hD080);
        hint_ready = 1'b1;
        @(negedge clk);
        chk("R12", "hint cleared when taken", 64'(hint_valid), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_form = 2'd0; in_base = '0; in_idx = '0;
        in_base_nat = 1'b0; in_idx_nat = 1'b0; in_imm = '0; in_excl = 1'b0;
        in_fault_kind = 1'b0; in_hint = '0; in_cacheable = 1'b1;
        ex_ready = 1'b1; hint_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_update();
        t_reg_update();
        t_imm_update();
        t_idx_nat();
        t_base_nat();
        t_noncache();
        t_bad_form();
        t_stall();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule